// File: doc/BRIEF.md
# Table-Driven Sine Source for a 12-bit DAC Path

This block produces a stream of 12-bit codes for a digital-to-analog converter. One period of a sine wave is held as sixteen fixed samples inside the block. While the run input is high, the block steps through those samples in a loop. A power-of-two divider sets how many clock cycles each sample is held, so the clock supplied to the block and the divider setting together set the tone frequency.

When the run input drops, the block goes idle. It can then do one of two things, chosen by a configuration input. It can release the output by lowering a drive-enable, so the pad floats. Or it can hold the output at the mid-scale code.

A second configuration input selects the output form. Single-ended codes are offset binary centred on 12'h800. Differential codes are two's complement values centred on zero. Each new run starts at sample 0 with a fresh divider count, so every burst begins at zero phase.

Top module: `sinegen_top`

## Requirements
- R1: After reset the block is idle: with `idle_tristate` low, `dac_drive_en` is 1 and `dac_code` is the idle code from R6.
- R2: In the first cycle after `trig_in` is sampled high while idle, `dac_code` shows sample 0 of the table, so each burst starts at zero phase.
- R3: While running, each table sample stays on `dac_code` for exactly 2^`rate_sel` clock cycles (`rate_sel` from 0 to 7).
- R4: Sample k (k = 0..15) in single-ended form equals 2048 + round(2047 * sin(2*pi*k/16)). The samples are 2048, 2831, 3495, 3939, 4095, 3939, 3495, 2831, 2048, 1265, 601, 157, 1, 157, 601, 1265.
- R5: In the first cycle after `trig_in` is sampled low, the output is idle.
- R6: The idle code is 12'h800 in single-ended form (`diff_mode` = 0) and 12'h000 in differential form (`diff_mode` = 1). With `idle_tristate` = 0 the idle output is driven (`dac_drive_en` = 1).
- R7: With `idle_tristate` = 1, `dac_drive_en` is 0 while idle. `dac_drive_en` is 1 in every running cycle, whatever `idle_tristate` is.
- R8: With `diff_mode` = 1, each running code is the single-ended sample minus 2048, written as 12-bit two's complement. This is the single-ended code with bit 11 inverted.
- R9: Holding `trig_in` high while running has no effect on the sequence. A stop followed by a new start restarts at sample 0 with a fresh hold count.
- R10: After sample 15 the sequence continues with sample 0 and keeps looping for as long as `trig_in` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sets the base sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Run gate: high runs the generator, low stops it |
| rate_sel | input | 3 | Hold exponent n; each sample lasts 2^n cycles |
| idle_tristate | input | 1 | Idle behaviour: 1 releases the output, 0 holds mid-scale |
| diff_mode | input | 1 | 1 selects two's complement codes centred on zero |
| dac_code | output | 12 | Sample code to the converter |
| dac_drive_en | output | 1 | Output driver enable; 0 means tri-state |

## Verification
The bench targets the slowest and fastest hold settings. With a hold of one cycle, an off-by-one in the divider repeats or skips a sample. With a hold of 128 cycles, a short counter wraps early. It runs bursts long enough to pass sample 15, which catches an index that stops at the end of the table or wraps to the wrong entry. It also stops and restarts in the middle of a burst: a design that keeps its phase across a stop resumes mid-table instead of at sample 0. Random bursts cover all four combinations of output form and idle behaviour. A swapped mid code or a tri-state that is also applied while running shows up as a code or enable mismatch in the first cycle after a start or a stop.

// File: rtl/sinegen_pkg.sv
// Package: shared constants and the fixed sine table for the sine source.
// Assumes a 16-entry table and 12-bit offset-binary samples.
package sinegen_pkg;

    localparam int CODE_W  = 12;
    localparam int TBL_N   = 16;
    localparam int IDX_W   = $clog2(TBL_N);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);

    // One sine period, offset binary: 2048 + round(2047*sin(2*pi*k/16)).
    function automatic code_t sine_sample(input idx_t k);
        code_t v;
        case (k)
            4'd0:  v = 12'd2048;
            4'd1:  v = 12'd2831;
            4'd2:  v = 12'd3495;
            4'd3:  v = 12'd3939;
            4'd4:  v = 12'd4095;
            4'd5:  v = 12'd3939;
            4'd6:  v = 12'd3495;
            4'd7:  v = 12'd2831;
            4'd8:  v = 12'd2048;
            4'd9:  v = 12'd1265;
            4'd10: v = 12'd601;
            4'd11: v = 12'd157;
            4'd12: v = 12'd1;
            4'd13: v = 12'd157;
            4'd14: v = 12'd601;
            default: v = 12'd1265;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sinegen_tick.sv
// Module: hold-time divider. Pulses step once every 2^rate clock cycles
// while run is high. Assumes clear is pulsed when a burst starts, so the
// count begins at zero. The mask is built bit by bit from rate.
module sinegen_tick #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              step
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Mask bit i is set when the hold exponent exceeds i.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (int'(rate) > i);
    end

    // Free-running count; its low bits are all ones at the last cycle of a hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // A step fires at the terminal count of the selected hold.
    always_comb begin
        step = run && ((cnt_q & mask) == mask);
    end

endmodule

// File: rtl/sinegen_phase.sv
// Module: table index register. Steps through the table and wraps after
// the last entry. Assumes clear takes priority over step.
module sinegen_phase
    import sinegen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output idx_t idx
);
    idx_t idx_q;

    // Index goes back to zero on clear and advances modulo the table size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q == idx_t'(TBL_N - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/sinegen_fmt.sv
// Module: output former. Looks up the current sample and applies the
// single-ended or two's complement form and the idle behaviour. It is
// purely combinational and assumes its inputs come from registers.
module sinegen_fmt
    import sinegen_pkg::*;
(
    input  idx_t  idx,
    input  logic  active,
    input  logic  diff,
    input  logic  idle_float,
    output code_t code,
    output logic  drive
);
    code_t raw;

    // Choose the table sample while running, the mid code while idle.
    always_comb begin
        raw = active ? sine_sample(idx) : MID_CODE;
    end

    // Differential form moves the centre to zero by inverting the top bit.
    always_comb begin
        code = diff ? (raw ^ MID_CODE) : raw;
    end

    // The driver is on while running, or while idle when mid-scale hold is chosen.
    always_comb begin
        drive = active || !idle_float;
    end

endmodule

// File: rtl/sinegen_top.sv
// Module: table-driven sine source top. Registers the run gate, clears
// the phase on each fresh start and joins the divider, index and former.
// Assumes trig_in is synchronous to clk.
module sinegen_top #(
    parameter int RATE_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trig_in,
    input  logic [RATE_W-1:0]              rate_sel,
    input  logic                           idle_tristate,
    input  logic                           diff_mode,
    output logic [sinegen_pkg::CODE_W-1:0] dac_code,
    output logic                           dac_drive_en
);
    import sinegen_pkg::*;

    logic running;
    logic start;
    logic step;
    idx_t phase_idx;

    // A start is a high trigger seen while idle.
    always_comb begin
        start = trig_in && !running;
    end

    // The run flag follows the trigger one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else begin
            running <= trig_in;
        end
    end

    sinegen_tick #(.RATE_W(RATE_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (running),
        .rate  (rate_sel),
        .step  (step)
    );

    sinegen_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (step),
        .idx   (phase_idx)
    );

    sinegen_fmt u_fmt (
        .idx        (phase_idx),
        .active     (running),
        .diff       (diff_mode),
        .idle_float (idle_tristate),
        .code       (dac_code),
        .drive      (dac_drive_en)
    );

endmodule

// File: rtl/sinegen_chk.sv
// Module: property checker for the sine source, bound to the top.
// Assumes configuration inputs change only while the block is idle.
module sinegen_chk
    import sinegen_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  trig_in,
    input logic  idle_tristate,
    input logic  diff_mode,
    input logic  running,
    input idx_t  phase_idx,
    input code_t dac_code,
    input logic  dac_drive_en
);
    logic seen_q;

    // Marks that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R7: the driver is on in every cycle after a high trigger was sampled.
    a_r7_drive_running: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(trig_in)) |-> dac_drive_en);

    // R5, R6: after a low trigger the code is the idle code for the chosen form.
    a_r5_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(trig_in)) |-> (dac_code == (diff_mode ? code_t'(0) : MID_CODE)));

    // R6: with mid-scale hold chosen, the output is never released.
    a_r6_hold_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_tristate |-> dac_drive_en);

    // R2: a fresh burst shows sample 0, the mid code in either form.
    a_r2_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (phase_idx == '0));

    // R10: while running the index stays put or moves one place, wrapping at the end.
    a_r10_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && running && $past(running)) |->
            (phase_idx == $past(phase_idx) || phase_idx == idx_t'($past(phase_idx) + 1'b1)));

endmodule

bind sinegen_top sinegen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_in       (trig_in),
    .idle_tristate (idle_tristate),
    .diff_mode     (diff_mode),
    .running       (running),
    .phase_idx     (phase_idx),
    .dac_code      (dac_code),
    .dac_drive_en  (dac_drive_en)
);

// File: tb/sim_sinegen_top.sv
module sim_sinegen_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic        idle_tristate = 1'b0;
    logic        diff_mode = 1'b0;
    logic [11:0] dac_code;
    logic        dac_drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sinegen_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_in       (trig_in),
        .rate_sel      (rate_sel),
        .idle_tristate (idle_tristate),
        .diff_mode     (diff_mode),
        .dac_code      (dac_code),
        .dac_drive_en  (dac_drive_en)
    );

    // Expected running code for table position k (R4, R8).
    function automatic logic [11:0] exp_sample(input int k, input logic diff);
        real ang;
        int  v;
        ang = 2.0 * 3.14159265358979 * real'(k % 16) / 16.0;
        v = 2048 + int'(2047.0 * $sin(ang));
        return diff ? (12'(v) ^ 12'h800) : 12'(v);
    endfunction

    task automatic check(input string req, input logic [11:0] exp_code, input logic exp_drv);
        checks++;
        if (dac_code !== exp_code || dac_drive_en !== exp_drv) begin
            errors++;
            $display("FAIL %s: code=%h drive=%b expected code=%h drive=%b",
                     req, dac_code, dac_drive_en, exp_code, exp_drv);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, diff_mode ? 12'h000 : 12'h800, !idle_tristate);
    endtask

    // Start a burst and check len cycles of output (R2, R3, R4, R10).
    task automatic run_burst(input int len, input string req);
        @(negedge clk);
        trig_in = 1'b1;
        for (int m = 0; m < len; m++) begin
            @(negedge clk);
            check(req, exp_sample(m >> rate_sel, diff_mode), 1'b1);
        end
    endtask

    // Stop and check the first idle cycle (R5, R6, R7).
    task automatic stop_check(input string req);
        trig_in = 1'b0;
        @(negedge clk);
        check_idle(req);
    endtask

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, mid-scale hold
        check_idle("R1");
        idle_tristate = 1'b1;
        #1 check_idle("R1_float");
        idle_tristate = 1'b0;

        // R3 R10: fastest hold, more than one full period
        rate_sel = 3'd0;
        run_burst(40, "R10_fast");
        stop_check("R5_fast");

        // R3: slowest hold, across two sample boundaries
        rate_sel = 3'd7;
        run_burst(300, "R3_slow");
        stop_check("R5_slow");

        // R9: stop mid-burst then restart begins at sample 0
        rate_sel = 3'd1;
        run_burst(11, "R9_first");
        stop_check("R9_stop");
        run_burst(12, "R9_restart");
        stop_check("R9_stop2");

        // R8 R7: differential form with tri-state idle
        diff_mode = 1'b1;
        idle_tristate = 1'b1;
        #1 check_idle("R7_idle");
        rate_sel = 3'd2;
        run_burst(70, "R8_diff");
        stop_check("R7_stop");

        // R6: differential idle held at zero
        idle_tristate = 1'b0;
        #1 check_idle("R6_diff_idle");

        // Random bursts across all settings
        for (int b = 0; b < 40; b++) begin
            rate_sel      = 3'($urandom % 8);
            diff_mode     = 1'($urandom % 2);
            idle_tristate = 1'($urandom % 2);
            #1 check_idle("R6_rand_idle");
            run_burst(1 + int'($urandom % 400), "R4_rand");
            stop_check("R5_rand");
            repeat (int'($urandom % 3)) begin
                @(negedge clk);
                check_idle("R7_rand_idle");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule